// File: doc/BRIEF.md
# Double-Word Memory Cycle Sequencer

This block is a cycle-counted memory controller that sits between a microcoded processor and a synchronous word RAM of 16-bit words. The processor starts a memory operation by loading an address. From then on an internal cycle counter advances on every clock, and reads and stores are legal only on fixed cycle numbers. The processor requests a read of the latched data or a store of a data word, and it stalls on three ready outputs until the sequencer can take the request.

Two words are fetched for every operation: the word at the loaded address and its partner word. Variant A is selected with `variant_b_i` low. In this variant the partner is found by forcing address bit 0 to one, and the latched data is only visible while the operation is active. Variant B is selected with `variant_b_i` high. Here the partner is found by inverting bit 0, and the latches keep their contents after the operation ends. Successive reads alternate between the two words under a toggle flag, so a pair can still be drained after the counter has passed the end of the operation. Illegal or pointless stores raise a one-cycle error pulse with a code, and they have no effect on any state.

The RAM has one read port and one write port. The RAM read data appears in the cycle after the read is issued. When a read and a write hit the same address in one cycle, the read returns the old contents.

Top module: `dw_mem_seq`

## Requirements
- R1: A load request taken while no operation is active starts one: in the following cycle the counter reads 1 and the operation is active. `ready_load_o` is low for as long as an operation is active. The counter then advances by one on every clock and saturates at 7.
- R2: When no operation is active, all three ready outputs are high. While an operation is active, `ready_rd_o` is high only at cycle 5 or later. Also while active, `ready_wr_o` is high only at cycle 5 or later in variant A, and at cycle 3 or later in variant B.
- R3: Variant A. The word at the loaded address is held in the low latch from cycle 5, and the word at (address OR 1) is held in the high latch from cycle 6. A read returns the low latch at cycle 5 and the high latch at cycle 6. From cycle 7 the operation is inactive, and a read then returns 0xFFFF.
- R4: Variant B. The word at the loaded address is held from cycle 4, and the word at (address XOR 1) from cycle 5. The operation is active through cycle 5 and inactive from cycle 6.
- R5: Variant B. Each taken read returns the high latch if the toggle is set and the low latch otherwise, and then it flips the toggle. This holds after the operation has ended as well. A load clears the toggle, so the first read after a load returns the low word.
- R6: Variant B. A store at cycle 3 writes `wdata_i` to the loaded address and flips the toggle. A store at cycle 4 writes to (address XOR 1) if the toggle is set, or to the loaded address if it is clear, and then flips the toggle.
- R7: Variant A. A store at cycle 5 writes the loaded address and sets the toggle. A store at cycle 6 writes (address OR 1) if the toggle is set. If the toggle is clear at cycle 6, nothing is written and the next cycle shows `err_o` high with code 1.
- R8: A store taken while no operation is active writes nothing and gives `err_o` high with code 2 in the next cycle. A store at cycle 5 in variant B writes nothing and gives code 3. An error pulse lasts one cycle for each offending store.
- R9: After reset, no operation is active, all ready outputs are high, `err_o` and both RAM enables are low, and both latches hold zero. This makes `rdata_o` read 0xFFFF in variant A and 0 in variant B.
- R10: A request made while its ready output is low has no effect. The loaded address, the latches and the toggle stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_b_i | input | 1 | Static timing variant: 0 = A, 1 = B |
| load_i | input | 1 | Address load request |
| addr_i | input | 16 | Address to load |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Store request |
| wdata_i | input | 16 | Store data |
| ready_load_o | output | 1 | Load can be taken this cycle |
| ready_rd_o | output | 1 | Read can be taken this cycle |
| ready_wr_o | output | 1 | Store can be taken this cycle |
| rdata_o | output | 16 | Read data, valid in the cycle a read is taken |
| err_o | output | 1 | One-cycle error or warning pulse |
| err_code_o | output | 2 | 1 = second store without first, 2 = idle store, 3 = late store |
| ram_re_o | output | 1 | RAM read enable |
| ram_raddr_o | output | 16 | RAM read address |
| ram_rdata_i | input | 16 | RAM read data, one cycle after the read |
| ram_we_o | output | 1 | RAM write enable |
| ram_waddr_o | output | 16 | RAM write address |
| ram_wdata_o | output | 16 | RAM write data |

## Verification
The bench targets the partner-address rule on odd and even addresses. A design that swapped OR and XOR would fetch or write the wrong neighbour: with an odd address in variant A it would reach the word below, and in variant B it would write the same word twice. It drains pairs in variant B after the counter has passed the end of the operation. There, a design that cleared its latches or its toggle at the end would return zeros or the low word twice. It issues a lone second store in both variants: variant A must flag it, and variant B must write it to the loaded address, not to the partner. It also sends requests that are not ready, including a load during an active operation. A design that took these would move the address or flip the toggle, and every later read would show the damage.

// File: rtl/dw_mem_pkg.sv
package dw_mem_pkg;

  localparam int CYC_W  = 3;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  localparam logic [CYC_W-1:0] CYC_MAX  = '1;
  localparam logic [CYC_W-1:0] RD_FIRST = CYC_W'(5);

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ORDER   = 2'd1,
    ERR_IDLE_ST = 2'd2,
    ERR_LATE_ST = 2'd3
  } err_code_e;

  // cycle in which the low word is in the RAM output register
  function automatic logic [CYC_W-1:0] cap_lo_cyc(input logic vb);
    return vb ? CYC_W'(3) : CYC_W'(4);
  endfunction

  function automatic logic [CYC_W-1:0] cap_hi_cyc(input logic vb);
    return vb ? CYC_W'(4) : CYC_W'(5);
  endfunction

  // last active cycle of an operation
  function automatic logic [CYC_W-1:0] last_cyc(input logic vb);
    return vb ? CYC_W'(5) : CYC_W'(6);
  endfunction

  // first legal store cycle
  function automatic logic [CYC_W-1:0] st_first_cyc(input logic vb);
    return vb ? CYC_W'(3) : CYC_W'(5);
  endfunction

  function automatic logic [ADDR_W-1:0] partner_addr(input logic vb,
                                                     input logic [ADDR_W-1:0] a);
    return vb ? {a[ADDR_W-1:1], ~a[0]} : {a[ADDR_W-1:1], 1'b1};
  endfunction

endpackage

// File: rtl/dw_cycle_ctr.sv
module dw_cycle_ctr
  import dw_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vb_i,
  input  logic              load_go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              act_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              act_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cyc_q  <= '0;
      addr_q <= '0;
    end else if (load_go_i) begin
      act_q  <= 1'b1;
      cyc_q  <= CYC_W'(1);
      addr_q <= addr_i;
    end else begin
      if (cyc_q != CYC_MAX) cyc_q <= cyc_q + CYC_W'(1);
      if (act_q && cyc_q == last_cyc(vb_i)) act_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign cyc_o  = cyc_q;
  assign addr_o = addr_q;

  AST_ACT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && !load_go_i && cyc_q == last_cyc(vb_i) |=> !act_q); // R4
  AST_ACT_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> cyc_q >= CYC_W'(1) && cyc_q <= last_cyc(vb_i)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |=> $stable(addr_q)); // R10

endmodule

// File: rtl/dw_read_path.sv
module dw_read_path
  import dw_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vb_i,
  input  logic              act_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_raddr_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] lo_q, hi_q;
  logic issue_lo, issue_hi, cap_lo, cap_hi;

  // RAM read goes out one cycle ahead of the capture cycle
  assign issue_lo = act_i && (cyc_i == cap_lo_cyc(vb_i) - CYC_W'(1));
  assign issue_hi = act_i && (cyc_i == cap_hi_cyc(vb_i) - CYC_W'(1));
  assign cap_lo   = act_i && (cyc_i == cap_lo_cyc(vb_i));
  assign cap_hi   = act_i && (cyc_i == cap_hi_cyc(vb_i));

  assign ram_re_o    = issue_lo || issue_hi;
  assign ram_raddr_o = issue_hi ? partner_addr(vb_i, addr_i) : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= ram_rdata_i;
      if (cap_hi) hi_q <= ram_rdata_i;
    end
  end

  always_comb begin
    if (vb_i)       rdata_o = tog_i ? hi_q : lo_q;
    else if (act_i) rdata_o = (cyc_i == RD_FIRST) ? lo_q : hi_q;
    else            rdata_o = '1;
  end

  AST_RE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |-> act_i); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> $stable(lo_q) && $stable(hi_q)); // R5

endmodule

// File: rtl/dw_store_path.sv
module dw_store_path
  import dw_mem_pkg::*;
(
  input  logic              vb_i,
  input  logic              act_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tog_i,
  input  logic              wr_go_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              flip_o,
  output logic              err_o,
  output err_code_e         code_o
);

  logic [ADDR_W-1:0] pair_a;
  assign pair_a      = partner_addr(vb_i, addr_i);
  assign ram_wdata_o = wdata_i;

  always_comb begin
    ram_we_o    = 1'b0;
    ram_waddr_o = addr_i;
    flip_o      = 1'b0;
    err_o       = 1'b0;
    code_o      = ERR_NONE;
    if (wr_go_i) begin
      if (!act_i) begin
        err_o  = 1'b1;
        code_o = ERR_IDLE_ST;
      end else if (cyc_i == st_first_cyc(vb_i)) begin
        ram_we_o = 1'b1;
        flip_o   = 1'b1;
      end else if (cyc_i == st_first_cyc(vb_i) + CYC_W'(1)) begin
        if (vb_i || tog_i) begin
          ram_we_o    = 1'b1;
          ram_waddr_o = tog_i ? pair_a : addr_i;
          flip_o      = 1'b1;
        end else begin
          err_o  = 1'b1;
          code_o = ERR_ORDER;
        end
      end else begin
        err_o  = 1'b1;
        code_o = ERR_LATE_ST;
      end
    end
  end

  always_comb begin
    if (ram_we_o) AST_WE_IN_WINDOW: assert (act_i && cyc_i >= st_first_cyc(vb_i)); // R6
    if (err_o)    AST_ERR_NO_WE: assert (!ram_we_o && !flip_o);                     // R10
  end

endmodule

// File: rtl/dw_mem_seq.sv
module dw_mem_seq
  import dw_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_b_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_load_o,
  output logic              ready_rd_o,
  output logic              ready_wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_raddr_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [DATA_W-1:0] ram_wdata_o
);

  logic              act;
  logic [CYC_W-1:0]  cyc;
  logic [ADDR_W-1:0] op_addr;
  logic              tog_q;
  logic              load_go, rd_go, wr_go;
  logic              st_flip, st_err;
  err_code_e         st_code;
  logic              err_q;
  err_code_e         code_q;

  assign ready_load_o = !act;
  assign ready_rd_o   = !act || (cyc >= RD_FIRST);
  assign ready_wr_o   = !act || (cyc >= st_first_cyc(variant_b_i));

  assign load_go = load_i && ready_load_o;
  assign rd_go   = rd_i && ready_rd_o;
  assign wr_go   = wr_i && ready_wr_o;

  dw_cycle_ctr u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vb_i      (variant_b_i),
    .load_go_i (load_go),
    .addr_i    (addr_i),
    .act_o     (act),
    .cyc_o     (cyc),
    .addr_o    (op_addr)
  );

  dw_read_path u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vb_i        (variant_b_i),
    .act_i       (act),
    .cyc_i       (cyc),
    .addr_i      (op_addr),
    .tog_i       (tog_q),
    .ram_rdata_i (ram_rdata_i),
    .ram_re_o    (ram_re_o),
    .ram_raddr_o (ram_raddr_o),
    .rdata_o     (rdata_o)
  );

  dw_store_path u_st (
    .vb_i        (variant_b_i),
    .act_i       (act),
    .cyc_i       (cyc),
    .addr_i      (op_addr),
    .tog_i       (tog_q),
    .wr_go_i     (wr_go),
    .wdata_i     (wdata_i),
    .ram_we_o    (ram_we_o),
    .ram_waddr_o (ram_waddr_o),
    .ram_wdata_o (ram_wdata_o),
    .flip_o      (st_flip),
    .err_o       (st_err),
    .code_o      (st_code)
  );

  // toggle: reads flip it only in variant B, stores flip it in both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (load_go) tog_q <= 1'b0;
    else              tog_q <= tog_q ^ (rd_go && variant_b_i) ^ st_flip;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      err_q  <= st_err;
      code_q <= st_err ? st_code : ERR_NONE;
    end
  end

  assign err_o      = err_q;
  assign err_code_o = code_q;

  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ready_load_o |=> act && cyc == CYC_W'(1)); // R1
  AST_TOG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ready_load_o |=> !tog_q); // R5
  AST_IDLE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !act |=> err_o && err_code_o == 2'd2); // R8
  AST_LOAD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && cyc != last_cyc(variant_b_i) |=> !ready_load_o); // R1
  AST_ERR_CODE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != 2'd0); // R8

endmodule

// File: tb/dw_mem_seq_tb_top.sv
`timescale 1ns/1ps
module dw_mem_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vb = 1'b0;
  logic        load_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic        ready_load_o, ready_rd_o, ready_wr_o, err_o;
  logic [1:0]  err_code_o;
  logic [15:0] rdata_o;
  logic        ram_re_o, ram_we_o;
  logic [15:0] ram_raddr_o, ram_waddr_o, ram_wdata_o;
  logic [15:0] ram_rdata_i = '0;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dw_mem_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .variant_b_i(vb),
    .load_i(load_i), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .ready_load_o(ready_load_o), .ready_rd_o(ready_rd_o), .ready_wr_o(ready_wr_o),
    .rdata_o(rdata_o), .err_o(err_o), .err_code_o(err_code_o),
    .ram_re_o(ram_re_o), .ram_raddr_o(ram_raddr_o), .ram_rdata_i(ram_rdata_i),
    .ram_we_o(ram_we_o), .ram_waddr_o(ram_waddr_o), .ram_wdata_o(ram_wdata_o)
  );

  function automatic logic [15:0] init_val(input int a);
    return 16'((a * 947) ^ 16'h5a3c);
  endfunction

  // bench RAM, read before write
  logic [15:0] mem [int];
  always @(posedge clk) begin
    if (ram_re_o) ram_rdata_i <= mem.exists(int'(ram_raddr_o)) ? mem[int'(ram_raddr_o)]
                                                               : init_val(int'(ram_raddr_o));
    if (ram_we_o) mem[int'(ram_waddr_o)] = ram_wdata_o;
  end

  // reference model
  logic [15:0] m_mem [int];
  bit m_act, m_tog, m_err;
  int m_cyc, m_addr, m_lo, m_hi, m_plo, m_phi, m_code;
  logic [15:0] last_rd;

  function automatic int mrd(input int a);
    return m_mem.exists(a) ? int'(m_mem[a]) : int'(init_val(a));
  endfunction

  function automatic int pair(input int a);
    return vb ? (a ^ 1) : (a | 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic model_reset();
    m_act = 0; m_tog = 0; m_err = 0; m_cyc = 0; m_addr = 0;
    m_lo = 0; m_hi = 0; m_plo = 0; m_phi = 0; m_code = 0;
  endtask

  task automatic step(input bit ld, input int a, input bit rd, input bit wr, input int wd);
    bit e_rl, e_rr, e_rw, lg, rg, wg, we, flip, n_err;
    int wa, n_code, ev, n_cyc;
    @(negedge clk);
    load_i = ld; addr_i = 16'(a); rd_i = rd; wr_i = wr; wdata_i = 16'(wd);
    #2;
    e_rl = !m_act;
    e_rr = !m_act || m_cyc >= 5;
    e_rw = !m_act || m_cyc >= (vb ? 3 : 5);
    chk(ready_load_o == e_rl, "R1 ready_load", int'(ready_load_o), int'(e_rl));
    chk(ready_rd_o == e_rr, "R2 ready_rd", int'(ready_rd_o), int'(e_rr));
    chk(ready_wr_o == e_rw, "R2 ready_wr", int'(ready_wr_o), int'(e_rw));
    chk(err_o == m_err, "R8 err_o", int'(err_o), int'(m_err));
    if (m_err) chk(int'(err_code_o) == m_code, m_code == 1 ? "R7 code" : "R8 code",
                   int'(err_code_o), m_code);
    lg = ld && e_rl; rg = rd && e_rr; wg = wr && e_rw;
    last_rd = rdata_o;
    if (rg) begin
      if (vb) ev = m_tog ? m_hi : m_lo;
      else    ev = m_act ? (m_cyc == 5 ? m_lo : m_hi) : 16'hffff;
      chk(int'(rdata_o) == ev, vb ? "R5 rdata" : "R3 rdata", int'(rdata_o), ev);
    end
    we = 0; wa = m_addr; flip = 0; n_err = 0; n_code = 0;
    if (wg) begin
      if (!m_act) begin n_err = 1; n_code = 2; end
      else if (vb) begin
        if (m_cyc == 3) begin we = 1; flip = 1; end
        else if (m_cyc == 4) begin we = 1; flip = 1; wa = m_tog ? (m_addr ^ 1) : m_addr; end
        else begin n_err = 1; n_code = 3; end
      end else begin
        if (m_cyc == 5) begin we = 1; flip = 1; end
        else if (m_tog) begin we = 1; flip = 1; wa = m_addr | 1; end
        else begin n_err = 1; n_code = 1; end
      end
    end
    chk(ram_we_o == we, vb ? "R6 we" : "R7 we", int'(ram_we_o), int'(we));
    if (we) begin
      chk(int'(ram_waddr_o) == wa, vb ? "R6 waddr" : "R7 waddr", int'(ram_waddr_o), wa);
      chk(ram_wdata_o == 16'(wd), vb ? "R6 wdata" : "R7 wdata", int'(ram_wdata_o), wd & 16'hffff);
    end
    // reads land in latch one cycle after they leave
    if (m_act && m_cyc == (vb ? 2 : 3)) m_plo = mrd(m_addr);
    if (m_act && m_cyc == (vb ? 3 : 4)) m_phi = mrd(pair(m_addr));
    @(posedge clk); #1;
    if (we) m_mem[wa] = 16'(wd);
    if (m_act && m_cyc == (vb ? 3 : 4)) m_lo = m_plo;
    if (m_act && m_cyc == (vb ? 4 : 5)) m_hi = m_phi;
    n_cyc = m_cyc < 7 ? m_cyc + 1 : 7;
    if (m_act && m_cyc == (vb ? 5 : 6)) m_act = 0;
    m_cyc = n_cyc;
    m_err = n_err; m_code = n_code;
    if (lg) begin m_act = 1; m_cyc = 1; m_addr = a & 16'hffff; m_tog = 0; end
    else m_tog = m_tog ^ (rg && vb) ^ flip;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset(input bit v);
    @(negedge clk);
    rst_n = 0; vb = v; load_i = 0; rd_i = 0; wr_i = 0;
    model_reset();
    repeat (2) @(negedge clk);
    #2;
    chk(ready_load_o && ready_rd_o && ready_wr_o, "R9 ready", 0, 1);
    chk(!err_o && !ram_we_o && !ram_re_o, "R9 outs", int'(err_o), 0);
    chk(rdata_o == (v ? 16'h0000 : 16'hffff), "R9 rdata", int'(rdata_o), v ? 0 : 16'hffff);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int a;
      a = 16'h0300 + int'($urandom_range(0, 15));
      step($urandom_range(0, 3) == 0, a, $urandom_range(0, 2) == 0,
           $urandom_range(0, 3) == 0, int'($urandom_range(0, 65535)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // ---------------- variant A
    do_reset(0);
    step(1, 16'h0104, 0, 0, 0);                      // cycle 1 follows
    #1; chk(!ready_load_o, "R1 load blocked", int'(ready_load_o), 0);
    idle(3);                                         // cycles 1..3
    step(0, 0, 1, 0, 0);                             // cycle 4: stalled read
    step(0, 0, 1, 0, 0);                             // cycle 5
    chk(last_rd == init_val(16'h0104), "R3 first word", int'(last_rd), int'(init_val(16'h0104)));
    step(0, 0, 1, 0, 0);                             // cycle 6
    chk(last_rd == init_val(16'h0105), "R3 second word", int'(last_rd), int'(init_val(16'h0105)));
    step(0, 0, 1, 0, 0);                             // cycle 7 idle
    chk(last_rd == 16'hffff, "R3 idle read", int'(last_rd), 16'hffff);
    // odd address double store
    step(1, 16'h0107, 0, 0, 0); idle(4);
    step(0, 0, 0, 1, 16'h1111); step(0, 0, 0, 1, 16'h2222);
    idle(1);
    chk(mem[16'h0107] == 16'h2222, "R7 odd pair", int'(mem[16'h0107]), 16'h2222);
    // lone second store
    step(1, 16'h0110, 0, 0, 0); idle(5);
    step(0, 0, 0, 1, 16'h3333); idle(1);
    // idle store
    step(0, 0, 0, 1, 16'h4444); idle(1);
    // stalled load and store during op
    step(1, 16'h0120, 0, 0, 0); idle(1);
    step(1, 16'h0130, 0, 1, 16'h5555); idle(2);
    step(0, 0, 1, 0, 0);
    chk(last_rd == init_val(16'h0120), "R10 address kept", int'(last_rd), int'(init_val(16'h0120)));
    idle(3);
    random_run(400);

    // ---------------- variant B
    do_reset(1);
    step(1, 16'h0203, 0, 0, 0); idle(4);
    step(0, 0, 1, 0, 0);                             // cycle 5
    chk(last_rd == init_val(16'h0203), "R4 first word", int'(last_rd), int'(init_val(16'h0203)));
    step(0, 0, 1, 0, 0);                             // cycle 6, op ended
    chk(last_rd == init_val(16'h0202), "R4 partner word", int'(last_rd), int'(init_val(16'h0202)));
    idle(2);
    step(0, 0, 1, 0, 0);
    chk(last_rd == init_val(16'h0203), "R5 drain wraps", int'(last_rd), int'(init_val(16'h0203)));
    // late pair drain at cycles 6 and 7
    step(1, 16'h0210, 0, 0, 0); idle(5);
    step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 0);
    chk(last_rd == init_val(16'h0211), "R5 late pair", int'(last_rd), int'(init_val(16'h0211)));
    // double store, then late store
    step(1, 16'h0220, 0, 0, 0); idle(2);
    step(0, 0, 0, 1, 16'hAAAA); step(0, 0, 0, 1, 16'hBBBB); step(0, 0, 0, 1, 16'hCCCC);
    idle(1);
    chk(mem[16'h0221] == 16'hBBBB, "R6 partner store", int'(mem[16'h0221]), 16'hBBBB);
    // lone store at cycle 4 hits loaded address
    step(1, 16'h0231, 0, 0, 0); idle(3);
    step(0, 0, 0, 1, 16'hDDDD); idle(2);
    chk(mem[16'h0231] == 16'hDDDD, "R6 lone second", int'(mem[16'h0231]), 16'hDDDD);
    // stalled read and load during op
    step(1, 16'h0240, 0, 0, 0); idle(1);
    step(1, 16'h0250, 1, 0, 0); idle(2);
    step(0, 0, 1, 0, 0);
    chk(last_rd == init_val(16'h0240), "R10 toggle kept", int'(last_rd), int'(init_val(16'h0240)));
    idle(2);
    step(0, 0, 0, 1, 16'h7777); idle(1);             // idle store
    random_run(400);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule